// File: doc/BRIEF.md
# Local/Remote Interrupt Router

This block gathers interrupt events for one end of a serial bridge and decides where they go. A single steering bit in its control word selects the route. In local mode, events collect in a status word with write-1-to-clear bits, and a level interrupt line goes out to the local interrupt controller. In remote mode, events collect in a pending word instead. A small forwarding state machine takes a snapshot of that word and offers it as the payload of an outbound interrupt packet. It holds the payload until the packet builder acknowledges it.

Software reaches four word registers through a simple read/write port. Reads are combinational on the address. The priority word reports the index of the lowest-numbered active status bit, and a write to it clears that bit. After any clearing write, the local line drops for one cycle. If bits are still set, it rises again, so an edge-sensitive controller sees a new interrupt.

The forwarding machine has two states. FWD_IDLE moves to FWD_SEND (transition *launch*) when the route is remote and the pending word is non-zero. FWD_SEND returns to FWD_IDLE (transition *done*) when the packet builder acknowledges. The machine holds FWD_SEND while no acknowledge arrives (transition *wait*).

Top module: `irq_router`

## Requirements
- R1: The register map uses word address 0 for control (bit 0 = route-local, reset value 1), 1 for status, 2 for pending and 3 for priority. Reads return the selected word zero-extended, and all words other than control reset to 0 (priority excepted, see R8).
- R2: With route-local = 1, a source high in a cycle sets its status bit at the next clock edge, and `irq_local` is high whenever a status bit is set and no clearing write happened in the previous cycle.
- R3: With route-local = 0, source events never set status bits and `irq_local` stays low. The events set pending bits instead.
- R4: In FWD_IDLE with route-local = 0 and pending non-zero, the next edge enters FWD_SEND and raises `pkt_req` with `pkt_status` equal to the pending word at that edge. `pkt_status` stays unchanged until `pkt_ack`, and it is 0 whenever `pkt_req` is low.
- R5: An edge with `pkt_req` and `pkt_ack` high clears the sent bits from pending (events in that same cycle survive) and returns to FWD_IDLE. Bits that arrived during the send launch another packet at the following edge.
- R6: Writing the status word clears every bit written as 1. A source event for the same bit in the same cycle wins, and the bit stays set.
- R7: After a write to status or priority, `irq_local` is low for the following cycle. It is high again the cycle after if status bits remain.
- R8: The priority word reads the index of the lowest set status bit (bit 0 highest priority), or 0x80000000 when no status bit is set. Writing it clears that bit.
- R9: Writing 1s to the pending word raises those bits as software events, routed exactly like source events: to status in local mode, to pending in remote mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq_in | input | NSRC | Interrupt source events, one per bit |
| irq_local | output | 1 | Level interrupt to the local controller |
| pkt_req | output | 1 | Outbound interrupt packet request |
| pkt_ack | input | 1 | Packet builder has taken the payload |
| pkt_status | output | NSRC | Interrupt bits carried by the packet |

## Verification
A wrong status or gap register shows on `irq_local` in the very next cycle. It also shows on the priority word as soon as software reads it. A wrong pending or snapshot word appears on `pkt_status` at the launch edge, or one cycle after an acknowledge when the relaunch carries the wrong bits. A machine stuck in either state shows as `pkt_req` failing to drop after an acknowledge, or failing to rise one cycle after pending becomes non-zero. The reference model compares all three outputs on every cycle, so each of these faults is caught within one or two cycles of its cause.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_PEND   = 2'd2,
        SEL_PRIO   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FWD_IDLE = 1'b0,
        FWD_SEND = 1'b1
    } fwd_state_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the lowest set bit is the last one kept.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = i[IW-1:0];
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_fwd_fsm.sv
module irq_fwd_fsm
    import irq_router_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            route_remote,
    input  logic [NSRC-1:0] set_vec,
    output logic [NSRC-1:0] pending,
    output logic            pkt_req,
    input  logic            pkt_ack,
    output logic [NSRC-1:0] pkt_status
);
    fwd_state_e      state_q, state_d;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] snap_q;
    logic            launch;
    logic            done;

    assign launch = (state_q == FWD_IDLE) && route_remote && (pend_q != '0);
    assign done   = (state_q == FWD_SEND) && pkt_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FWD_IDLE: if (launch) state_d = FWD_SEND;
            FWD_SEND: if (done)   state_d = FWD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FWD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            snap_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(done ? snap_q : '0)) | set_vec;
            if (launch) snap_q <= pend_q;
        end
    end

    always_comb begin
        pkt_req    = 1'b0;
        pkt_status = '0;
        unique case (state_q)
            FWD_IDLE: ;
            FWD_SEND: begin
                pkt_req    = 1'b1;
                pkt_status = snap_q;
            end
        endcase
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_local,
    output logic            pkt_req,
    input  logic            pkt_ack,
    output logic [NSRC-1:0] pkt_status
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            route_local;
    logic [NSRC-1:0] status_q;
    logic            gap_q;
    logic [NSRC-1:0] pending;
    logic [IW-1:0]   top_idx;
    logic            top_any;
    logic [NSRC-1:0] src_set;
    logic [NSRC-1:0] status_set;
    logic [NSRC-1:0] pend_set;
    logic [NSRC-1:0] clr_vec;
    logic            wr_ctrl, wr_status, wr_pend, wr_prio;
    reg_sel_e        sel;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
    assign wr_status = reg_wr && (sel == SEL_STATUS);
    assign wr_pend   = reg_wr && (sel == SEL_PEND);
    assign wr_prio   = reg_wr && (sel == SEL_PRIO);

    assign src_set    = irq_in | (wr_pend ? reg_wdata[NSRC-1:0] : '0);
    assign status_set = route_local ? src_set : '0;
    assign pend_set   = route_local ? '0 : src_set;

    irq_prio_enc #(.N(NSRC)) u_enc (
        .vec (status_q),
        .idx (top_idx),
        .any (top_any)
    );

    always_comb begin
        clr_vec = '0;
        if (wr_status) clr_vec = reg_wdata[NSRC-1:0];
        if (wr_prio && top_any) clr_vec = NSRC'(1) << top_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_local <= 1'b1;
            status_q    <= '0;
            gap_q       <= 1'b0;
        end else begin
            if (wr_ctrl) route_local <= reg_wdata[0];
            status_q <= (status_q & ~clr_vec) | status_set;
            gap_q    <= wr_status || wr_prio;
        end
    end

    irq_fwd_fsm #(.NSRC(NSRC)) u_fwd (
        .clk          (clk),
        .rst_n        (rst_n),
        .route_remote (!route_local),
        .set_vec      (pend_set),
        .pending      (pending),
        .pkt_req      (pkt_req),
        .pkt_ack      (pkt_ack),
        .pkt_status   (pkt_status)
    );

    assign irq_local = route_local && (status_q != '0) && !gap_q;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL:   reg_rdata[0] = route_local;
            SEL_STATUS: reg_rdata[NSRC-1:0] = status_q;
            SEL_PEND:   reg_rdata[NSRC-1:0] = pending;
            SEL_PRIO: begin
                if (top_any) reg_rdata[IW-1:0] = top_idx;
                else         reg_rdata[DW-1]   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic            irq_local,
    input logic            pkt_req,
    input logic            pkt_ack,
    input logic [NSRC-1:0] pkt_status,
    input logic            route_local,
    input logic [NSRC-1:0] status_q
);
    assert_local_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_local |-> (route_local && (status_q != '0)));

    assert_remote_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !route_local |=> ((status_q & ~$past(status_q)) == '0));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_ack) |=> (pkt_req && $stable(pkt_status)));

    assert_req_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> (pkt_status != '0));

    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_ack) |=> !pkt_req);

    assert_clear_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd3)) |=> !irq_local);
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .irq_local   (irq_local),
    .pkt_req     (pkt_req),
    .pkt_ack     (pkt_ack),
    .pkt_status  (pkt_status),
    .route_local (route_local),
    .status_q    (status_q)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
    localparam int NSRC = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic [NSRC-1:0] irq_in = '0;
    logic            irq_local;
    logic            pkt_req;
    logic            pkt_ack = 1'b0;
    logic [NSRC-1:0] pkt_status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_router #(.NSRC(NSRC), .DW(DW)) u_irq_router (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .irq_local(irq_local), .pkt_req(pkt_req), .pkt_ack(pkt_ack),
        .pkt_status(pkt_status)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    bit              m_local, m_gap, m_busy;
    logic [NSRC-1:0] m_status, m_pend, m_snap;
    logic [NSRC-1:0] t_set, t_clr, t_pend;
    bit              t_ack, t_launch;

    function automatic logic [NSRC-1:0] lowest(input logic [NSRC-1:0] v);
        for (int i = 0; i < NSRC; i++) if (v[i]) return NSRC'(1) << i;
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_local = 1'b1; m_gap = 1'b0; m_busy = 1'b0;
            m_status = '0; m_pend = '0; m_snap = '0;
        end else begin
            t_set = irq_in;
            if (reg_wr && reg_addr == 2'd2) t_set = t_set | reg_wdata[NSRC-1:0];
            t_clr = '0;
            if (reg_wr && reg_addr == 2'd1) t_clr = reg_wdata[NSRC-1:0];
            if (reg_wr && reg_addr == 2'd3) t_clr = lowest(m_status);
            t_ack    = m_busy && pkt_ack;
            t_launch = !m_busy && !m_local && (m_pend != '0);
            t_pend   = m_pend;
            if (t_ack) t_pend = t_pend & ~m_snap;
            if (!m_local) t_pend = t_pend | t_set;
            if (t_launch) begin m_snap = m_pend; m_busy = 1'b1; end
            else if (t_ack) m_busy = 1'b0;
            m_pend = t_pend;
            m_status = m_status & ~t_clr;
            if (m_local) m_status = m_status | t_set;
            m_gap = reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd3);
            if (reg_wr && reg_addr == 2'd0) m_local = reg_wdata[0];
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            #1;
            check("R2 irq_local", DW'(irq_local), DW'(m_local && (m_status != '0) && !m_gap));
            check("R4 pkt_req", DW'(pkt_req), DW'(m_busy));
            check("R4 pkt_status", DW'(pkt_status), DW'(m_busy ? m_snap : '0));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] b);
        @(negedge clk); irq_in = b;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic ack();
        @(negedge clk); pkt_ack = 1'b1;
        @(negedge clk); pkt_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset values
        rd(2'd0, 32'h1, "R1 ctrl reset");
        rd(2'd1, 32'h0, "R1 status reset");
        rd(2'd2, 32'h0, "R1 pending reset");
        rd(2'd3, 32'h8000_0000, "R8 prio empty");
        check("R2 irq_local reset", DW'(irq_local), 32'h0);

        // R2: local collection
        pulse(8'h28);
        rd(2'd1, 32'h28, "R2 status set");
        check("R2 irq_local high", DW'(irq_local), 32'h1);
        rd(2'd3, 32'h3, "R8 prio lowest");

        // R6 and R7: clear write with bits remaining
        wr(2'd1, 32'h08);
        #1 check("R7 gap low", DW'(irq_local), 32'h0);
        @(negedge clk); #1 check("R7 reassert", DW'(irq_local), 32'h1);
        rd(2'd3, 32'h5, "R8 prio next");

        // R8: priority write clears the reported bit
        wr(2'd3, 32'h0);
        rd(2'd1, 32'h0, "R8 prio clear");
        check("R7 stays low", DW'(irq_local), 32'h0);

        // R6: set wins over clear in the same cycle
        @(negedge clk); irq_in = 8'h04; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h04;
        @(negedge clk); irq_in = '0; reg_wr = 1'b0;
        rd(2'd1, 32'h04, "R6 set wins");
        wr(2'd1, 32'hFF);
        rd(2'd1, 32'h0, "R6 clear all");

        // R3 and R4: remote forwarding
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h0, "R1 ctrl write");
        pulse(8'h02);
        idle(1); #1;
        check("R4 req raised", DW'(pkt_req), 32'h1);
        check("R4 payload", DW'(pkt_status), 32'h02);
        rd(2'd1, 32'h0, "R3 status untouched");
        check("R3 irq_local low", DW'(irq_local), 32'h0);

        // R5: arrival during send stays pending
        pulse(8'h10);
        rd(2'd2, 32'h12, "R5 pending during send");
        check("R4 payload stable", DW'(pkt_status), 32'h02);
        ack();
        #1 check("R5 req drop", DW'(pkt_req), 32'h0);
        rd(2'd2, 32'h10, "R5 pending after ack");
        check("R5 relaunch", DW'(pkt_req), 32'h1);
        check("R5 relaunch payload", DW'(pkt_status), 32'h10);
        ack();
        idle(2);
        rd(2'd2, 32'h0, "R5 pending empty");

        // R9: software set, remote route
        wr(2'd2, 32'h81);
        idle(1); #1;
        check("R9 packet from write", DW'(pkt_status), 32'h81);
        ack();
        idle(2);

        // R9: software set, local route
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h40);
        rd(2'd1, 32'h40, "R9 status from write");
        rd(2'd2, 32'h0, "R9 pending untouched");
        check("R9 irq_local", DW'(irq_local), 32'h1);
        wr(2'd1, 32'h40);
        idle(3);
        summary();
    end
endmodule